// File: doc/BRIEF.md
# Priority Address Window Translator

This block sits between a local bus and a PCI host interface. It turns each local-bus address into a PCI-bus address and a cycle type. Software sets up a small bank of windows. Each window is a pair of registers: a base register (local address, size, enable, prefetchable attribute) and a map register (upper PCI address bits, cycle type, low-address control).

For every address that arrives on the lookup port, all windows are compared in parallel. The window with the lowest index that is enabled and contains the address supplies the translation. Overlapping windows are therefore legal. Growing an early window hides any later window that it now covers, and shrinking it again reveals that window. Software uses this to borrow a window temporarily, for example for configuration accesses. A configuration-type window either forces the two lowest PCI address bits to zero (type 0 style) or passes them through from the host (type 1 style).

Lookups enter through a valid/ready handshake and leave one cycle later through a second valid/ready handshake. Register writes use a simple single-cycle write strobe.

Top module: `lbus_win_xlate`

## Requirements
- R1: After reset every window is disabled, `out_valid` is 0 and `in_ready` is 1, so the first lookup misses.
- R2: On a hit, PCI address bits below the window size come from the local address. The bits at and above the window size come from map bits 31:16, which stand for PCI address bits 31:16; PCI bits 15:0 are never taken from the map.
- R3: When several enabled windows contain the address, the lowest-numbered one supplies the translation, and `out_win` reports its index.
- R4: A window whose base bit 0 (enable) is 0 never matches, whatever its other fields hold.
- R5: Base bits 31:20 give the 1 MB-aligned local base. Base bits 7:4 give a size code c, and the window spans 2^(20+c) bytes. Codes 4, 8 and 9 give 16 MB, 256 MB and 512 MB. Codes above 11 behave as 11.
- R6: `out_type` carries map bits 3:1 on a hit: 001 I/O, 011 memory, 111 multiple memory, 101 configuration. Window 2 always reports 001, whatever its map type field holds.
- R7: When the reported type is 101 and map bit 0 is 0, PCI bits 1:0 are forced to 00. When map bit 0 is 1, bits 1:0 pass through from the local address. For any other type, bits 1:0 always pass through.
- R8: A miss gives `out_miss`=1, `out_type`=000, `out_addr`=0, `out_pref`=0 and `out_win`=0.
- R9: On a hit, base bit 1 (prefetchable) appears on `out_pref`.
- R10: Enlarging window 0 so that it covers window 1's range hides window 1. Shrinking window 0 again restores window 1's translation with no other write.
- R11: An accepted lookup (`in_valid` and `in_ready` both 1 at a clock edge) appears on the outputs after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, all outputs hold steady.
- R12: A register write (`cfg_we`, `cfg_sel` = window index, `cfg_map` 0 for base or 1 for map) takes effect from the next clock edge. A lookup accepted at the same edge as the write uses the old setting. Writes with `cfg_sel` of 3 or more are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Window index for the write |
| cfg_map | input | 1 | 0 writes the base register, 1 writes the map register |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Lookup address valid |
| in_ready | output | 1 | Lookup can be accepted |
| in_addr | input | 32 | Local-bus address |
| out_valid | output | 1 | Translation result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Translated PCI address |
| out_type | output | 3 | Cycle type code, 000 on a miss |
| out_miss | output | 1 | No enabled window matched |
| out_pref | output | 1 | Prefetchable attribute of the winning window |
| out_win | output | 2 | Index of the winning window |

## Verification
The assertions assume that `out_ready` is a plain level from the consumer and that `in_valid` only matters when `in_ready` is high. The stall property also assumes that nothing else moves the result register while it is held. The bench drives every input half a cycle away from the active edge. It holds `out_ready` low only inside the stall scenario, and there it offers a second lookup that the block must not take. Register writes are issued only with legal window indices, except for the one write with an out-of-range index that must be ignored. Apart from the same-edge check, writes are never issued in the same cycle as a lookup, so the bench's reference model can track each window's state exactly.

// File: rtl/lwx_pkg.sv
package lwx_pkg;

   // cycle type codes carried in map bits 3:1
   typedef enum logic [2:0] {
      CYC_NONE    = 3'b000,
      CYC_IO      = 3'b001,
      CYC_MEM     = 3'b011,
      CYC_CFG     = 3'b101,
      CYC_MEMMULT = 3'b111
   } cyc_t;

   localparam int REG_W = 32;

   typedef struct packed {
      logic        hit;
      logic [31:0] addr;
      logic [2:0]  ctype;
      logic        pref;
   } xl_res_t;

endpackage

// File: rtl/lwx_window.sv
module lwx_window
   import lwx_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MIN_SHIFT = 20,
   parameter bit IO_ONLY   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic              map_we,
   input  logic [REG_W-1:0]  wdata,
   input  logic [ADDR_W-1:0] look_addr,
   output xl_res_t           res
);

   localparam int MAX_CODE = ADDR_W - 1 - MIN_SHIFT;
   localparam int SH_W     = $clog2(ADDR_W) + 1;

   logic [REG_W-1:0]  base_q, map_q;
   logic [3:0]        code_eff;
   logic [SH_W-1:0]   shamt;
   logic [ADDR_W-1:0] keep_mask, base_addr, map_addr, xaddr;
   logic [2:0]        ctype;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         map_q  <= '0;
      end else begin
         if (base_we) base_q <= wdata;
         if (map_we)  map_q  <= wdata;
      end
   end

   always_comb begin
      code_eff  = (int'(base_q[7:4]) > MAX_CODE) ? 4'(MAX_CODE) : base_q[7:4];
      shamt     = SH_W'(MIN_SHIFT) + SH_W'(code_eff);
      keep_mask = ~({ADDR_W{1'b1}} << shamt);
      base_addr = base_q[ADDR_W-1:0] & ({ADDR_W{1'b1}} << MIN_SHIFT);
      map_addr  = {map_q[31:16], 16'h0000};
   end

   generate
      if (IO_ONLY) begin : g_io
         assign ctype = CYC_IO;
      end else begin : g_any
         assign ctype = map_q[3:1];
      end
   endgenerate

   always_comb begin
      xaddr = (map_addr & ~keep_mask) | (look_addr & keep_mask);
      if (ctype == CYC_CFG && !map_q[0]) xaddr[1:0] = 2'b00;
      res.hit   = base_q[0] && ((look_addr & ~keep_mask) == (base_addr & ~keep_mask));
      res.addr  = xaddr;
      res.ctype = ctype;
      res.pref  = base_q[1];
   end

endmodule

// File: rtl/lwx_prio_sel.sv
module lwx_prio_sel #(
   parameter int NUM_WIN = 3,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_WIN-1:0] hit_vec,
   output logic               any_hit,
   output logic [SEL_W-1:0]   win_idx
);

   always_comb begin
      any_hit = 1'b0;
      win_idx = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any_hit = 1'b1;
            win_idx = SEL_W'(i);
         end
      end
   end

endmodule

// File: rtl/lwx_out_stage.sv
module lwx_out_stage
   import lwx_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  xl_res_t          nxt_res,
   input  logic [SEL_W-1:0] nxt_win,
   input  logic             out_ready,
   output logic             out_valid,
   output xl_res_t          cur_res,
   output logic [SEL_W-1:0] cur_win
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         cur_res   <= '0;
         cur_win   <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         cur_res   <= nxt_res;
         cur_win   <= nxt_win;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/lbus_win_xlate.sv
module lbus_win_xlate
   import lwx_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_WIN   = 3,
   parameter int IO_WIN    = 2,
   parameter int MIN_SHIFT = 20,
   localparam int SEL_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic              cfg_map,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [2:0]        out_type,
   output logic              out_miss,
   output logic              out_pref,
   output logic [SEL_W-1:0]  out_win
);

   generate
      if (ADDR_W != 32) begin : g_bad_aw
         $error("lbus_win_xlate: map layout needs ADDR_W == 32");
      end
      if (NUM_WIN < 1 || NUM_WIN > 4) begin : g_bad_nw
         $error("lbus_win_xlate: NUM_WIN must be 1..4");
      end
      if (MIN_SHIFT < 16 || MIN_SHIFT > ADDR_W - 1) begin : g_bad_ms
         $error("lbus_win_xlate: MIN_SHIFT out of range");
      end
   endgenerate

   xl_res_t              win_res [NUM_WIN];
   logic [NUM_WIN-1:0]   hit_vec;
   logic                 any_hit;
   logic [SEL_W-1:0]     win_idx;
   xl_res_t              sel_res, cur_res;
   logic                 take;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
         lwx_window #(
            .ADDR_W   (ADDR_W),
            .MIN_SHIFT(MIN_SHIFT),
            .IO_ONLY  (gi == IO_WIN)
         ) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_we  (cfg_we && !cfg_map && cfg_sel == SEL_W'(gi)),
            .map_we   (cfg_we &&  cfg_map && cfg_sel == SEL_W'(gi)),
            .wdata    (cfg_wdata),
            .look_addr(in_addr),
            .res      (win_res[gi])
         );
         assign hit_vec[gi] = win_res[gi].hit;
      end
   endgenerate

   lwx_prio_sel #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_prio (
      .hit_vec(hit_vec),
      .any_hit(any_hit),
      .win_idx(win_idx)
   );

   always_comb begin
      sel_res = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (any_hit && win_idx == SEL_W'(i)) sel_res = win_res[i];
      end
   end

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   lwx_out_stage #(.SEL_W(SEL_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .nxt_res  (sel_res),
      .nxt_win  (any_hit ? win_idx : '0),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .cur_res  (cur_res),
      .cur_win  (out_win)
   );

   assign out_addr = cur_res.addr;
   assign out_type = cur_res.ctype;
   assign out_pref = cur_res.pref;
   assign out_miss = !cur_res.hit;

endmodule

// File: rtl/lwx_chk.sv
module lwx_chk #(
   parameter int ADDR_W = 32,
   parameter int SEL_W  = 2,
   parameter int IO_WIN = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic [2:0]        out_type,
   input logic              out_miss,
   input logic              out_pref,
   input logic [SEL_W-1:0]  out_win
);

   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

   // R11
   accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_type)
                                     && $stable(out_miss) && $stable(out_pref) && $stable(out_win)));

   // R8
   miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_miss) |-> (out_type == 3'b000 && out_addr == '0 && !out_pref && out_win == '0));

   // R6
   io_win_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_miss && out_win == SEL_W'(IO_WIN)) |-> out_type == 3'b001);

endmodule

bind lbus_win_xlate lwx_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .IO_WIN(IO_WIN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_addr (out_addr),
   .out_type (out_type),
   .out_miss (out_miss),
   .out_pref (out_pref),
   .out_win  (out_win)
);

// File: tb/lbus_win_xlate_tb.sv
module lbus_win_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_map = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_addr = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_addr;
   logic [2:0]  out_type;
   logic        out_miss;
   logic        out_pref;
   logic [1:0]  out_win;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m_base [3];
   logic [31:0] m_map  [3];

   always #2.5 clk = ~clk;

   lbus_win_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_map(cfg_map),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_type(out_type),
      .out_miss(out_miss), .out_pref(out_pref), .out_win(out_win)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model written from the requirements
   task automatic model(input logic [31:0] a, output bit miss, output logic [1:0] win,
                        output logic [2:0] ty, output logic [31:0] pa, output bit pf);
      miss = 1'b1; win = 0; ty = 3'b000; pa = 0; pf = 1'b0;
      for (int i = 2; i >= 0; i--) begin
         logic [63:0] keep;
         int c;
         c = int'(m_base[i][7:4]);
         if (c > 11) c = 11;
         keep = (64'd1 << (20 + c)) - 64'd1;
         if (m_base[i][0] && ((a & ~keep[31:0]) == ({m_base[i][31:20], 20'h0} & ~keep[31:0]))) begin
            miss = 1'b0;
            win  = 2'(i);
            ty   = (i == 2) ? 3'b001 : m_map[i][3:1];
            pa   = ({m_map[i][31:16], 16'h0} & ~keep[31:0]) | (a & keep[31:0]);
            if (ty == 3'b101 && !m_map[i][0]) pa[1:0] = 2'b00;
            pf   = m_base[i][1];
         end
      end
   endtask

   task automatic wr(input int sel, input bit is_map, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_map = is_map; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel < 3) begin
         if (is_map) m_map[sel] = d; else m_base[sel] = d;
      end
   endtask

   task automatic look(input logic [31:0] a, input string tag);
      bit e_miss, e_pf; logic [1:0] e_win; logic [2:0] e_ty; logic [31:0] e_pa;
      model(a, e_miss, e_win, e_ty, e_pa, e_pf);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, {tag, " R11 valid"}, 64'(out_valid), 64'd1);
      chk(out_miss == e_miss, {tag, " miss"}, 64'(out_miss), 64'(e_miss));
      chk(out_win == e_win, {tag, " win"}, 64'(out_win), 64'(e_win));
      chk(out_type == e_ty, {tag, " type"}, 64'(out_type), 64'(e_ty));
      chk(out_addr == e_pa, {tag, " addr"}, 64'(out_addr), 64'(e_pa));
      chk(out_pref == e_pf, {tag, " pref"}, 64'(out_pref), 64'(e_pf));
   endtask

   task automatic t_reset();
      for (int i = 0; i < 3; i++) begin m_base[i] = 0; m_map[i] = 0; end
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
      look(32'h4000_0000, "R1 first lookup");
      chk(out_miss == 1'b1, "R1 miss", 64'(out_miss), 64'd1);
   endtask

   task automatic t_basic();
      wr(0, 0, 32'h4000_0081);            // 256 MB, enabled
      wr(0, 1, 32'h0000_0006);            // memory
      wr(1, 0, 32'h5000_0083);            // 256 MB, prefetchable
      wr(1, 1, 32'h1000_000E);            // multiple memory
      wr(2, 0, 32'h6000_0041);            // 16 MB
      wr(2, 1, 32'h0000_0006);            // memory code, forced to I/O
      look(32'h4123_4567, "R2 win0");
      look(32'h5ABC_DEF3, "R9 R2 win1 pref");
      chk(out_pref == 1'b1, "R9 pref", 64'(out_pref), 64'd1);
      look(32'h60FF_FFFE, "R6 win2 io");
      chk(out_type == 3'b001, "R6 io type", 64'(out_type), 64'd1);
      look(32'h4FFF_FFFF, "R5 256M top edge");
      look(32'h6100_0000, "R5 16M past edge");
      look(32'h0000_1000, "R8 miss");
   endtask

   task automatic t_disable();
      wr(2, 0, 32'h6000_0040);
      look(32'h6000_0010, "R4 disabled");
      chk(out_miss == 1'b1, "R4 miss", 64'(out_miss), 64'd1);
      wr(2, 0, 32'h6000_0041);
      look(32'h6000_0010, "R4 re-enabled");
   endtask

   task automatic t_config();
      wr(0, 0, 32'h4000_0091);            // 512 MB hides window 1
      look(32'h5123_4567, "R10 hidden");
      chk(out_win == 2'd0, "R10 win0 covers", 64'(out_win), 64'd0);
      wr(1, 0, 32'h6100_0041);            // 16 MB config window
      wr(1, 1, 32'h0000_000A);            // config, low bits forced
      look(32'h6100_0803, "R7 cfg type0");
      chk(out_addr[1:0] == 2'b00, "R7 forced low", 64'(out_addr[1:0]), 64'd0);
      wr(1, 1, 32'h0000_000B);            // config, low bits passed
      look(32'h6112_3803, "R7 cfg type1");
      chk(out_addr[1:0] == 2'b11, "R7 passed low", 64'(out_addr[1:0]), 64'd3);
      wr(0, 1, 32'h0000_0006);
      look(32'h4000_0003, "R7 mem low passes");
      // restore window 1, then shrink window 0
      wr(1, 0, 32'h5000_0083);
      wr(1, 1, 32'h1000_000E);
      look(32'h5123_4567, "R10 still hidden");
      wr(0, 0, 32'h4000_0081);
      look(32'h5123_4567, "R10 revealed");
      chk(out_win == 2'd1, "R10 win1 back", 64'(out_win), 64'd1);
      look(32'h1000_0000, "R3 R5 miss low");
   endtask

   task automatic t_overlap();
      wr(2, 0, 32'h4000_0081);            // window 2 duplicates window 0
      look(32'h4800_0000, "R3 prio over win2");
      wr(0, 0, 32'h4000_0080);
      look(32'h4800_0000, "R3 win2 after win0 off");
      wr(0, 0, 32'h4000_00F1);            // code 15 acts as 11
      look(32'h7FFF_FFFC, "R5 code clamp");
      wr(0, 0, 32'h4000_0081);
      wr(2, 0, 32'h6000_0041);
   endtask

   task automatic t_stall();
      bit e_miss, e_pf; logic [1:0] e_win; logic [2:0] e_ty; logic [31:0] e_pa;
      model(32'h4000_1234, e_miss, e_win, e_ty, e_pa, e_pf);
      @(negedge clk);
      in_valid = 1'b1; in_addr = 32'h4000_1234; out_ready = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b0, "R11 not ready", 64'(in_ready), 64'd0);
      in_addr = 32'h5000_0000;
      @(negedge clk);
      chk(out_valid == 1'b1, "R11 held valid", 64'(out_valid), 64'd1);
      chk(out_addr == e_pa, "R11 held addr", 64'(out_addr), 64'(e_pa));
      chk(out_win == e_win, "R11 held win", 64'(out_win), 64'(e_win));
      in_valid = 1'b0; out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R11 drained", 64'(out_valid), 64'd0);
   endtask

   task automatic t_same_edge();
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_map = 1'b0; cfg_wdata = 32'h4000_0080;
      in_valid = 1'b1; in_addr = 32'h4000_0040;
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0;
      chk(out_miss == 1'b0, "R12 old setting used", 64'(out_miss), 64'd0);
      m_base[0] = 32'h4000_0080;
      look(32'h4000_0040, "R12 new setting");
      chk(out_miss == 1'b1, "R12 now disabled", 64'(out_miss), 64'd1);
      wr(3, 0, 32'h4000_0081);            // out-of-range index, ignored
      look(32'h4000_0040, "R12 bad index ignored");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_disable();
      t_config();
      t_overlap();
      t_stall();
      t_same_edge();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule